// File: doc/BRIEF.md
# Serial debug command front end

This block receives characters from a host over an asynchronous serial line and turns them into the control pulses and small registers a debug controller needs. Letters are commands and their case matters: lowercase letters read or step, uppercase letters write or run. Hex digit characters are turned into 4-bit values with a strobe. A semicolon or a carriage return closes a payload.

The block also keeps the payload registers that some commands fill. After the instruction-load command, successive hex digits are shifted into a 6-bit debug instruction register. After the address-load command, they are shifted into the memory address register. After either bank-select command, a single hex digit chooses the memory banks.

The bit period is fixed at build time as `CLK_HZ / BAUD` clocks, and it must be at least 10 clocks. Nothing is sent back to the host. Every output is a stream of single-cycle pulses with no back-pressure. Consumers must accept a pulse in the cycle it appears, and at most one pulse appears for each received character.

Top module: `dbgc_top`

## Requirements
- R1: The receiver takes frames of 1 start bit, 8 data bits sent LSB first, no parity and 1 stop bit, with a bit period of `CLK_HZ/BAUD` clocks. A frame whose stop bit is sampled low is discarded and produces no pulse.
- R2: A received '0'-'9' or 'A'-'F' gives a one-cycle `hex_vld` pulse, with `hex_nib` holding the digit's value (0-15).
- R3: Command letters give a one-cycle pulse on a single bit of `cmd_pulse`. The bit map is: 0 'x', 1 'y', 2 'p', 3 'X', 4 'Y', 5 'P', 6 'I', 7 'M', 8 'R', 9 'r', 10 'S', 11 'W', 12 'G', 13 'g'. Letters of the other case (for example 'i' or 's') are not commands.
- R4: A received ';' (0x3B) or carriage return (0x0D) gives a one-cycle `eod` pulse.
- R5: Any other character gives no pulse and leaves `dbg_instr`, `mem_addr` and `bank_sel` unchanged.
- R6: At most one of `cmd_pulse`, `hex_vld` and `eod` is high in any cycle, and each pulse lasts exactly one cycle.
- R7: 'I' clears `dbg_instr`. Each following hex digit then gives `dbg_instr <= {dbg_instr[1:0], nib}`. This continues until `eod` or another command letter, so "I08;" leaves 001000.
- R8: 'M' clears `mem_addr`. Each following hex digit then shifts 4 bits in from the LSB end, dropping the top bits, until `eod` or another command letter.
- R9: The first hex digit after 'W' or 'G' loads `bank_sel` with the digit's bits [2:0]: bit 0 selects X, bit 1 selects Y and bit 2 selects P. Bit 3 and any later digits are ignored.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| cmd_pulse | output | 14 | One-hot command pulse, bit map as in R3 |
| hex_vld | output | 1 | Hex digit strobe |
| hex_nib | output | 4 | Value of the hex digit |
| eod | output | 1 | End-of-data pulse |
| dbg_instr | output | IW (6) | Debug instruction register |
| mem_addr | output | AW (16) | Memory address register |
| bank_sel | output | 3 | Bank select: bit 0 X, bit 1 Y, bit 2 P |

## Verification
The hardest cases to reach are those that depend on the history of the command stream. One is a hex digit arriving after a bank-select digit has already been used. Another is a digit that follows a terminator, or follows a command letter that does not own a payload. The bench mixes directed sequences such as "W3" followed by '4', and "I08;" followed by a stray digit, with long random streams drawn mostly from the command, hex and terminator characters. This makes such orderings common. Frames with a low stop bit are driven on purpose, and the bench checks that the payload registers stay unchanged afterwards.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int NCMD = 14;

  typedef enum logic [3:0] {
    C_RDX = 4'd0, C_RDY = 4'd1, C_RDP = 4'd2,
    C_WRX = 4'd3, C_WRY = 4'd4, C_WRP = 4'd5,
    C_INS = 4'd6, C_ADR = 4'd7, C_RUN = 4'd8,
    C_STP = 4'd9, C_HLT = 4'd10, C_BKW = 4'd11,
    C_BKG = 4'd12, C_REL = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_INSTR = 2'd1,
    TGT_ADDR  = 2'd2,
    TGT_BANK  = 2'd3
  } tgt_e;
endpackage

// File: rtl/dbgc_rx.sv
module dbgc_rx #(
  parameter int DIV = 833
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic       byte_vld,
  output logic [7:0] byte_dat
);
  localparam int CW   = $clog2(DIV + 1);
  localparam int HALF = DIV / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_e;

  st_e          st;
  logic [CW-1:0] cnt;
  logic [2:0]   bitn;
  logic [7:0]   shreg;
  logic         rx_m, rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m     <= 1'b1;
      rx_s     <= 1'b1;
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      rx_m     <= rxd;
      rx_s     <= rx_m;
      byte_vld <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!rx_s) st <= S_START;
        end
        S_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == CW'(DIV - 1)) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[7:1]};
            if (bitn == 3'd7) st <= S_STOP;
            else bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
            st  <= S_IDLE;
            if (rx_s) begin
              byte_vld <= 1'b1;
              byte_dat <= shreg;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbgc_decode.sv
module dbgc_decode
  import dbgc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_vld,
  input  logic [7:0]      byte_dat,
  output logic [NCMD-1:0] cmd_pulse,
  output logic            hex_vld,
  output logic [3:0]      hex_nib,
  output logic            eod
);
  logic [NCMD-1:0] c_cmd;
  logic            c_hex, c_eod;
  logic [3:0]      c_nib;

  always_comb begin
    c_cmd = '0;
    c_hex = 1'b0;
    c_eod = 1'b0;
    c_nib = '0;
    if (byte_dat >= "0" && byte_dat <= "9") begin
      c_hex = 1'b1;
      c_nib = byte_dat[3:0];
    end else if (byte_dat >= "A" && byte_dat <= "F") begin
      c_hex = 1'b1;
      c_nib = byte_dat[3:0] + 4'd9;
    end else begin
      case (byte_dat)
        "x":   c_cmd[C_RDX] = 1'b1;
        "y":   c_cmd[C_RDY] = 1'b1;
        "p":   c_cmd[C_RDP] = 1'b1;
        "X":   c_cmd[C_WRX] = 1'b1;
        "Y":   c_cmd[C_WRY] = 1'b1;
        "P":   c_cmd[C_WRP] = 1'b1;
        "I":   c_cmd[C_INS] = 1'b1;
        "M":   c_cmd[C_ADR] = 1'b1;
        "R":   c_cmd[C_RUN] = 1'b1;
        "r":   c_cmd[C_STP] = 1'b1;
        "S":   c_cmd[C_HLT] = 1'b1;
        "W":   c_cmd[C_BKW] = 1'b1;
        "G":   c_cmd[C_BKG] = 1'b1;
        "g":   c_cmd[C_REL] = 1'b1;
        8'h3B: c_eod = 1'b1;
        8'h0D: c_eod = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pulse <= '0;
      hex_vld   <= 1'b0;
      hex_nib   <= '0;
      eod       <= 1'b0;
    end else begin
      cmd_pulse <= byte_vld ? c_cmd : '0;
      hex_vld   <= byte_vld & c_hex;
      eod       <= byte_vld & c_eod;
      if (byte_vld && c_hex) hex_nib <= c_nib;
    end
  end
endmodule

// File: rtl/dbgc_nibreg.sv
module dbgc_nibreg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic [3:0]   nib,
  output logic [W-1:0] q
);
  logic [W+3:0] cat;
  assign cat = {q, nib};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (shift) q <= cat[W-1:0];
  end
endmodule

// File: rtl/dbgc_top.sv
module dbgc_top
  import dbgc_pkg::*;
#(
  parameter int CLK_HZ = 48_000_000,
  parameter int BAUD   = 57_600,
  parameter int IW     = 6,
  parameter int AW     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rxd,
  output logic [NCMD-1:0] cmd_pulse,
  output logic            hex_vld,
  output logic [3:0]      hex_nib,
  output logic            eod,
  output logic [IW-1:0]   dbg_instr,
  output logic [AW-1:0]   mem_addr,
  output logic [2:0]      bank_sel
);
  localparam int DIV = CLK_HZ / BAUD;

  logic       byte_vld;
  logic [7:0] byte_dat;
  tgt_e       tgt;
  logic       any_cmd;

  dbgc_rx #(.DIV(DIV)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd),
    .byte_vld(byte_vld), .byte_dat(byte_dat)
  );

  dbgc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .cmd_pulse(cmd_pulse), .hex_vld(hex_vld), .hex_nib(hex_nib), .eod(eod)
  );

  assign any_cmd = |cmd_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt      <= TGT_NONE;
      bank_sel <= '0;
    end else if (any_cmd) begin
      if (cmd_pulse[C_INS])                           tgt <= TGT_INSTR;
      else if (cmd_pulse[C_ADR])                      tgt <= TGT_ADDR;
      else if (cmd_pulse[C_BKW] || cmd_pulse[C_BKG])  tgt <= TGT_BANK;
      else                                            tgt <= TGT_NONE;
    end else if (eod) begin
      tgt <= TGT_NONE;
    end else if (hex_vld && tgt == TGT_BANK) begin
      bank_sel <= hex_nib[2:0];
      tgt      <= TGT_NONE;
    end
  end

  dbgc_nibreg #(.W(IW)) u_instr (
    .clk(clk), .rst_n(rst_n), .clr(cmd_pulse[C_INS]),
    .shift(hex_vld && tgt == TGT_INSTR), .nib(hex_nib), .q(dbg_instr)
  );

  dbgc_nibreg #(.W(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(cmd_pulse[C_ADR]),
    .shift(hex_vld && tgt == TGT_ADDR), .nib(hex_nib), .q(mem_addr)
  );
endmodule

// File: rtl/dbgc_chk.sv
module dbgc_chk
  import dbgc_pkg::*;
#(
  parameter int IW = 6,
  parameter int AW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCMD-1:0] cmd_pulse,
  input logic            hex_vld,
  input logic            eod,
  input logic [IW-1:0]   dbg_instr,
  input logic [AW-1:0]   mem_addr,
  input logic [2:0]      bank_sel
);
  logic any_p;
  assign any_p = hex_vld | eod | (|cmd_pulse);

  a_r6_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pulse, hex_vld, eod}));

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    any_p |=> !any_p);

  a_r7_instr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_instr) |-> ($past(hex_vld) || $past(cmd_pulse[C_INS])));

  a_r7_instr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse[C_INS] |=> dbg_instr == '0);

  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> ($past(hex_vld) || $past(cmd_pulse[C_ADR])));

  a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_sel) |-> $past(hex_vld));
endmodule

bind dbgc_top dbgc_chk #(.IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_pulse(cmd_pulse), .hex_vld(hex_vld),
  .eod(eod), .dbg_instr(dbg_instr), .mem_addr(mem_addr), .bank_sel(bank_sel)
);

// File: tb/test_dbgc_top.sv
module test_dbgc_top;
  localparam int CLK_HZ = 200;
  localparam int BAUD   = 20;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam int IW     = 6;
  localparam int AW     = 16;
  localparam int NCMD   = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rxd = 1'b1;
  logic [NCMD-1:0] cmd_pulse;
  logic            hex_vld, eod;
  logic [3:0]      hex_nib;
  logic [IW-1:0]   dbg_instr;
  logic [AW-1:0]   mem_addr;
  logic [2:0]      bank_sel;

  always #2.5 clk = ~clk;

  dbgc_top #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .IW(IW), .AW(AW)) i_dbgc_top (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .cmd_pulse(cmd_pulse),
    .hex_vld(hex_vld), .hex_nib(hex_nib), .eod(eod), .dbg_instr(dbg_instr),
    .mem_addr(mem_addr), .bank_sel(bank_sel)
  );

  int errors = 0;
  int checks = 0;
  int cmd_cnt [NCMD];
  int hex_cnt = 0, eod_cnt = 0, tot_cnt = 0;
  int last_nib = 0;
  int cycles = 0;
  bit done = 0;

  int exp_instr = 0, exp_addr = 0, exp_bank = 0, exp_tgt = 0;

  initial for (int i = 0; i < NCMD; i++) cmd_cnt[i] = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int i = 0; i < NCMD; i++) if (cmd_pulse[i]) begin cmd_cnt[i]++; tot_cnt++; end
      if (hex_vld) begin hex_cnt++; tot_cnt++; last_nib = int'(hex_nib); end
      if (eod) begin eod_cnt++; tot_cnt++; end
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hex_of(input logic [7:0] b);
    if (b >= "0" && b <= "9") return int'(b) - 48;
    if (b >= "A" && b <= "F") return int'(b) - 55;
    return -1;
  endfunction

  function automatic int cmd_of(input logic [7:0] b);
    string m = "xypXYPIMRrSWGg";
    for (int i = 0; i < NCMD; i++) if (m[i] == b) return i;
    return -1;
  endfunction

  task automatic drive_frame(input logic [7:0] b, input bit stop_hi);
    @(negedge clk) rxd = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxd = stop_hi;
    repeat (DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (stop_hi ? 6 : 3 * DIV) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit good);
    int t0 = tot_cnt, h0 = hex_cnt, e0 = eod_cnt;
    int c0 [NCMD];
    int hv = hex_of(b), cv = cmd_of(b);
    bit ev = (b == 8'h3B) || (b == 8'h0D);
    for (int i = 0; i < NCMD; i++) c0[i] = cmd_cnt[i];
    drive_frame(b, good);
    if (!good) begin
      check(tot_cnt == t0, "R1 bad stop bit pulses", tot_cnt - t0, 0);
    end else if (hv >= 0) begin
      check(hex_cnt - h0 == 1 && tot_cnt - t0 == 1, "R2 hex strobe", tot_cnt - t0, 1);
      check(last_nib == hv, "R2 hex value", last_nib, hv);
      if (exp_tgt == 1) exp_instr = ((exp_instr << 4) | hv) & ((1 << IW) - 1);
      else if (exp_tgt == 2) exp_addr = ((exp_addr << 4) | hv) & ((1 << AW) - 1);
      else if (exp_tgt == 3) begin exp_bank = hv & 7; exp_tgt = 0; end
    end else if (cv >= 0) begin
      check(cmd_cnt[cv] - c0[cv] == 1 && tot_cnt - t0 == 1, "R3 command pulse", tot_cnt - t0, 1);
      if (cv == 6) begin exp_tgt = 1; exp_instr = 0; end
      else if (cv == 7) begin exp_tgt = 2; exp_addr = 0; end
      else if (cv == 11 || cv == 12) exp_tgt = 3;
      else exp_tgt = 0;
    end else if (ev) begin
      check(eod_cnt - e0 == 1 && tot_cnt - t0 == 1, "R4 end of data", tot_cnt - t0, 1);
      exp_tgt = 0;
    end else begin
      check(tot_cnt == t0, "R5 unknown char pulses", tot_cnt - t0, 0);
    end
    check(int'(dbg_instr) == exp_instr, "R7 instr register", int'(dbg_instr), exp_instr);
    check(int'(mem_addr) == exp_addr, "R8 address register", int'(mem_addr), exp_addr);
    check(int'(bank_sel) == exp_bank, "R9 bank select", int'(bank_sel), exp_bank);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i], 1'b1);
  endtask

  initial begin
    string pool = "xypXYPIMRrSWGg;0123456789ABCDEFisz";
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(cmd_pulse == '0 && !hex_vld && !eod, "R10 reset pulses", int'(cmd_pulse), 0);
    check(dbg_instr == '0 && mem_addr == '0 && bank_sel == '0, "R10 reset registers",
          int'(mem_addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    send_str("I08;");
    check(dbg_instr == 6'b001000, "R7 I08 result", int'(dbg_instr), 8);
    send_str("5");
    send_str("M1234;");
    send_str("M12345\r");
    check(mem_addr == 16'h2345, "R8 address truncation", int'(mem_addr), 16'h2345);
    send_str("W5");
    send_str("GF");
    check(bank_sel == 3'd7, "R9 bit 3 ignored", int'(bank_sel), 7);
    send_str("W34");
    check(bank_sel == 3'd3, "R9 only first digit", int'(bank_sel), 3);
    send_str("is");
    send_str("IF");
    send_str("x1");
    send_str("IFa");
    send(8'h41, 1'b0);
    send(8'h78, 1'b0);
    send_str("I1");
    send_str("RrSgyYpP");

    for (int n = 0; n < 140; n++) begin
      logic [7:0] b;
      if ($urandom % 8 == 0) b = 8'($urandom);
      else b = pool[$urandom % pool.len()];
      if (n % 37 == 5) send(b, 1'b0);
      else send(b, 1'b1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule